// File: doc/BRIEF.md
# Vector Expand-Load Unit

This unit fills a 128-bit vector register from memory under a lane mask. A command carries a byte start address with any alignment, a lane mask, an element size of 32 or 64 bits, a merge-or-zero select and a 128-bit source vector. Memory holds the elements of the active lanes packed next to each other. The unit reads them in order, one element per memory request, and writes them into the lanes whose mask bit is set, from the lowest lane upward. Lanes whose mask bit is clear take the matching source lane or zero.

The memory side is a strobe-and-reply interface. A request is a single-cycle strobe that carries an address and a width. The memory answers every request with exactly one reply, one or more cycles later. Only one request is outstanding at any time. After the last active lane has been written, the finished vector appears on the result port together with a one-cycle done pulse. A new command can be accepted in that same done cycle.

Top module: `xld_expand_load`

## Requirements
- R1: `cmd_ready` is high only while the unit is idle or in its done cycle. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `mem_req_valid` is never high while `cmd_ready` is high.
- R2: With `cmd_wide`=0 the vector has four 32-bit lanes, and lane j is bits [32j+31:32j], controlled by mask bit j. With `cmd_wide`=1 it has two 64-bit lanes, and lane j is bits [64j+63:64j], controlled by mask bit j. Mask bits 3:2 are then ignored. In 32-bit mode bits 63:32 of a reply are ignored. `mem_req_wide` reports the element size of each request.
- R3: The k-th active lane, counting from zero in ascending lane order, receives the element stored at the start address plus k element sizes. The element is read little-endian.
- R4: The first request goes to the start address, whatever its alignment. Each later request goes one element size further: 4 bytes for 32-bit elements, 8 bytes for 64-bit elements. Inactive lanes do not advance the address.
- R5: An inactive lane takes the matching source lane when `cmd_zero`=0 (merge) and zero when `cmd_zero`=1.
- R6: Each command issues exactly as many requests as it has active lanes. Inactive lanes are never requested.
- R7: `res_done` is high for the one cycle after the edge that takes the last reply. `res_data` holds the finished vector from that cycle until the next command is accepted.
- R8: Each request strobe lasts a single cycle. No new request is issued until the reply to the previous one has arrived.
- R9: After reset, `cmd_ready` is 1, `mem_req_valid` is 0, `res_done` is 0 and `res_data` is 0.
- R10: A command presented during the done cycle is accepted at once, without an idle cycle in between.
- R11: A reply that arrives while no request is outstanding has no effect on `res_data` or on the unit's state.
- R12: A command with no active lane makes no memory request. Its `res_done` is high in the cycle that follows acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_addr | input | ADDR_W | Byte start address of the packed elements |
| cmd_mask | input | VEC_W/NARROW_W | Lane mask, bit j selects lane j |
| cmd_wide | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| cmd_zero | input | 1 | 0: inactive lanes keep source, 1: inactive lanes cleared |
| cmd_src | input | VEC_W | Source vector for merge mode |
| mem_req_valid | output | 1 | Single-cycle read request strobe |
| mem_req_addr | output | ADDR_W | Byte address of the requested element |
| mem_req_wide | output | 1 | Requested element is 64 bits wide |
| mem_rsp_valid | input | 1 | Read reply present |
| mem_rsp_data | input | WIDE_W | Reply data, little-endian, element in low bits |
| res_data | output | VEC_W | Destination vector |
| res_done | output | 1 | One-cycle completion pulse |

## Verification
Completion of one command and acceptance of the next can fall in the same cycle. Commands are queued one after another, so each new command is already waiting when the done pulse of the previous one appears. The reference model takes it in that cycle, and every clock the bench compares `cmd_ready`, the request strobe and address, the done pulse and the result vector. A second overlap is a stray reply that arrives while the unit is idle. The bench injects one between commands and requires the result to be unchanged afterwards. Reply latency rotates between one and three cycles, and the lane masks include empty, full and scattered patterns in both element sizes.

// File: rtl/xld_pkg.sv
package xld_pkg;

    typedef enum logic [1:0] {
        XLD_IDLE   = 2'd0,
        XLD_ISSUE  = 2'd1,
        XLD_WAIT   = 2'd2,
        XLD_FINISH = 2'd3
    } xld_state_e;

endpackage

// File: rtl/xld_lane_init.sv
// Builds the starting vector at command acceptance: inactive slots take
// source or zero, active slots start at zero until their element arrives.
module xld_lane_init #(
    parameter int unsigned VEC_W    = 128,
    parameter int unsigned NARROW_W = 32,
    parameter int unsigned WIDE_W   = 64
) (
    input  logic [VEC_W-1:0]            src_i,
    input  logic [VEC_W/NARROW_W-1:0]   mask_i,
    input  logic                        wide_i,
    input  logic                        zero_i,
    output logic [VEC_W-1:0]            vec_o
);
    localparam int unsigned SLOTS = VEC_W / NARROW_W;
    localparam int unsigned RATIO = WIDE_W / NARROW_W;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        localparam int unsigned WL = k / RATIO;
        logic act;
        assign act = wide_i ? mask_i[WL] : mask_i[k];
        assign vec_o[k*NARROW_W +: NARROW_W] =
            (act || zero_i) ? '0 : src_i[k*NARROW_W +: NARROW_W];
    end
endmodule

// File: rtl/xld_lane_pick.sv
// Lowest pending lane: the next lane to receive a memory element.
module xld_lane_pick #(
    parameter int unsigned MASK_W = 4,
    localparam int unsigned IDX_W = $clog2(MASK_W)
) (
    input  logic [MASK_W-1:0] pend_i,
    output logic [IDX_W-1:0]  idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = MASK_W - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xld_lane_insert.sv
// Writes one returned element into the selected lane of the vector.
module xld_lane_insert #(
    parameter int unsigned VEC_W    = 128,
    parameter int unsigned NARROW_W = 32,
    parameter int unsigned WIDE_W   = 64,
    localparam int unsigned IDX_W   = $clog2(VEC_W / NARROW_W)
) (
    input  logic [VEC_W-1:0]  vec_i,
    input  logic              en_i,
    input  logic              wide_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [WIDE_W-1:0] data_i,
    output logic [VEC_W-1:0]  vec_o
);
    localparam int unsigned SLOTS = VEC_W / NARROW_W;
    localparam int unsigned RATIO = WIDE_W / NARROW_W;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        localparam int unsigned WL   = k / RATIO;
        localparam int unsigned PART = k % RATIO;
        logic hit;
        logic [NARROW_W-1:0] piece;
        assign hit   = en_i && (wide_i ? (idx_i == IDX_W'(WL)) : (idx_i == IDX_W'(k)));
        assign piece = wide_i ? data_i[PART*NARROW_W +: NARROW_W] : data_i[NARROW_W-1:0];
        assign vec_o[k*NARROW_W +: NARROW_W] = hit ? piece : vec_i[k*NARROW_W +: NARROW_W];
    end
endmodule

// File: rtl/xld_expand_load.sv
module xld_expand_load
    import xld_pkg::*;
#(
    parameter int unsigned VEC_W    = 128,
    parameter int unsigned NARROW_W = 32,
    parameter int unsigned WIDE_W   = 64,
    parameter int unsigned ADDR_W   = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid,
    output logic                          cmd_ready,
    input  logic [ADDR_W-1:0]             cmd_addr,
    input  logic [VEC_W/NARROW_W-1:0]     cmd_mask,
    input  logic                          cmd_wide,
    input  logic                          cmd_zero,
    input  logic [VEC_W-1:0]              cmd_src,
    output logic                          mem_req_valid,
    output logic [ADDR_W-1:0]             mem_req_addr,
    output logic                          mem_req_wide,
    input  logic                          mem_rsp_valid,
    input  logic [WIDE_W-1:0]             mem_rsp_data,
    output logic [VEC_W-1:0]              res_data,
    output logic                          res_done
);
    localparam int unsigned MASK_W = VEC_W / NARROW_W;
    localparam int unsigned WLANES = VEC_W / WIDE_W;
    localparam int unsigned IDX_W  = $clog2(MASK_W);
    localparam int unsigned NB     = NARROW_W / 8;
    localparam int unsigned WB     = WIDE_W / 8;
    localparam logic [MASK_W-1:0] WIDE_KEEP = MASK_W'((1 << WLANES) - 1);

    typedef struct packed {
        xld_state_e          st;
        logic                wide;
        logic [MASK_W-1:0]   pend;
        logic [ADDR_W-1:0]   base;
        logic [ADDR_W-1:0]   off;
        logic [VEC_W-1:0]    res;
    } ctx_t;

    ctx_t ctx_q, ctx_d;

    logic [MASK_W-1:0] used_mask;
    logic [VEC_W-1:0]  init_vec;
    logic [VEC_W-1:0]  ins_vec;
    logic [IDX_W-1:0]  pick_idx;
    logic              accept;
    logic              take_rsp;
    logic [ADDR_W-1:0] step;

    assign used_mask = cmd_wide ? (cmd_mask & WIDE_KEEP) : cmd_mask;
    assign cmd_ready = (ctx_q.st == XLD_IDLE) || (ctx_q.st == XLD_FINISH);
    assign accept    = cmd_valid && cmd_ready;
    assign take_rsp  = (ctx_q.st == XLD_WAIT) && mem_rsp_valid;
    assign step      = ctx_q.wide ? ADDR_W'(WB) : ADDR_W'(NB);

    xld_lane_init #(.VEC_W(VEC_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_init (
        .src_i  (cmd_src),
        .mask_i (used_mask),
        .wide_i (cmd_wide),
        .zero_i (cmd_zero),
        .vec_o  (init_vec)
    );

    xld_lane_pick #(.MASK_W(MASK_W)) u_pick (
        .pend_i (ctx_q.pend),
        .idx_o  (pick_idx)
    );

    xld_lane_insert #(.VEC_W(VEC_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_ins (
        .vec_i  (ctx_q.res),
        .en_i   (take_rsp),
        .wide_i (ctx_q.wide),
        .idx_i  (pick_idx),
        .data_i (mem_rsp_data),
        .vec_o  (ins_vec)
    );

    always_comb begin
        ctx_d = ctx_q;
        case (ctx_q.st)
            XLD_ISSUE: ctx_d.st = XLD_WAIT;
            XLD_WAIT: begin
                if (mem_rsp_valid) begin
                    ctx_d.res  = ins_vec;
                    ctx_d.pend = ctx_q.pend & ~(MASK_W'(1) << pick_idx);
                    ctx_d.off  = ctx_q.off + step;
                    ctx_d.st   = (ctx_d.pend == '0) ? XLD_FINISH : XLD_ISSUE;
                end
            end
            default: ctx_d.st = XLD_IDLE;
        endcase
        if (accept) begin
            ctx_d.base = cmd_addr;
            ctx_d.off  = '0;
            ctx_d.wide = cmd_wide;
            ctx_d.pend = used_mask;
            ctx_d.res  = init_vec;
            ctx_d.st   = (used_mask != '0) ? XLD_ISSUE : XLD_FINISH;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign mem_req_valid = (ctx_q.st == XLD_ISSUE);
    assign mem_req_addr  = ctx_q.base + ctx_q.off;
    assign mem_req_wide  = ctx_q.wide;
    assign res_data      = ctx_q.res;
    assign res_done      = (ctx_q.st == XLD_FINISH);
endmodule

// File: rtl/xld_expand_load_chk.sv
module xld_expand_load_chk #(
    parameter int unsigned VEC_W    = 128,
    parameter int unsigned NARROW_W = 32,
    parameter int unsigned WIDE_W   = 64,
    parameter int unsigned ADDR_W   = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cmd_valid,
    input logic                      cmd_ready,
    input logic [ADDR_W-1:0]         cmd_addr,
    input logic [VEC_W/NARROW_W-1:0] cmd_mask,
    input logic                      cmd_wide,
    input logic                      cmd_zero,
    input logic [VEC_W-1:0]          cmd_src,
    input logic                      mem_req_valid,
    input logic [ADDR_W-1:0]         mem_req_addr,
    input logic                      mem_rsp_valid,
    input logic [VEC_W-1:0]          res_data,
    input logic                      res_done
);
    localparam int unsigned MASK_W = VEC_W / NARROW_W;
    localparam int unsigned RATIO  = WIDE_W / NARROW_W;
    localparam int unsigned WLANES = VEC_W / WIDE_W;
    localparam logic [MASK_W-1:0] WIDE_KEEP = MASK_W'((1 << WLANES) - 1);

    logic              outst_q;
    logic [7:0]        nreq_q;
    logic [ADDR_W-1:0] exp_addr_q;
    logic [ADDR_W-1:0] step_q;
    logic [MASK_W-1:0] cap_mask_q;
    logic              cap_wide_q;
    logic              cap_zero_q;
    logic [VEC_W-1:0]  cap_src_q;
    logic              inactive_ok;
    logic              acc;

    assign acc = cmd_valid && cmd_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q    <= 1'b0;
            nreq_q     <= '0;
            exp_addr_q <= '0;
            step_q     <= '0;
            cap_mask_q <= '0;
            cap_wide_q <= 1'b0;
            cap_zero_q <= 1'b0;
            cap_src_q  <= '0;
        end else begin
            if (mem_req_valid)      outst_q <= 1'b1;
            else if (mem_rsp_valid) outst_q <= 1'b0;
            if (acc) begin
                nreq_q     <= '0;
                exp_addr_q <= cmd_addr;
                step_q     <= cmd_wide ? ADDR_W'(WIDE_W / 8) : ADDR_W'(NARROW_W / 8);
                cap_mask_q <= cmd_wide ? (cmd_mask & WIDE_KEEP) : cmd_mask;
                cap_wide_q <= cmd_wide;
                cap_zero_q <= cmd_zero;
                cap_src_q  <= cmd_src;
            end else if (mem_req_valid) begin
                nreq_q     <= nreq_q + 8'd1;
                exp_addr_q <= exp_addr_q + step_q;
            end
        end
    end

    always_comb begin
        inactive_ok = 1'b1;
        for (int k = 0; k < MASK_W; k++) begin
            if (!(cap_wide_q ? cap_mask_q[k / RATIO] : cap_mask_q[k])) begin
                if (res_data[k*NARROW_W +: NARROW_W] !=
                    (cap_zero_q ? '0 : cap_src_q[k*NARROW_W +: NARROW_W]))
                    inactive_ok = 1'b0;
            end
        end
    end

    assert_ready_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !mem_req_valid);
    assert_req_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr == exp_addr_q));
    assert_inactive_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |-> inactive_ok);
    assert_req_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |-> (32'(nreq_q) == $countones(cap_mask_q)));
    assert_done_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |-> cmd_ready);
    assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);
    assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !outst_q);
endmodule

bind xld_expand_load xld_expand_load_chk #(
    .VEC_W(VEC_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_addr      (cmd_addr),
    .cmd_mask      (cmd_mask),
    .cmd_wide      (cmd_wide),
    .cmd_zero      (cmd_zero),
    .cmd_src       (cmd_src),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .res_data      (res_data),
    .res_done      (res_done)
);

// File: tb/tb_xld_expand_load.sv
module tb_xld_expand_load;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         cmd_valid;
    logic         cmd_ready;
    logic [31:0]  cmd_addr;
    logic [3:0]   cmd_mask;
    logic         cmd_wide;
    logic         cmd_zero;
    logic [127:0] cmd_src;
    logic         mem_req_valid;
    logic [31:0]  mem_req_addr;
    logic         mem_req_wide;
    logic         mem_rsp_valid;
    logic [63:0]  mem_rsp_data;
    logic [127:0] res_data;
    logic         res_done;

    always #5 clk = ~clk;

    xld_expand_load dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_mask(cmd_mask), .cmd_wide(cmd_wide), .cmd_zero(cmd_zero), .cmd_src(cmd_src),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_wide(mem_req_wide),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .res_data(res_data), .res_done(res_done)
    );

    int compared = 0;
    int mismatched = 0;
    bit running = 0;
    bit finished = 0;

    logic [7:0] mem [0:255];

    function automatic logic [63:0] rd(input logic [31:0] a, input int n);
        logic [63:0] r = '0;
        for (int b = 0; b < n; b++) r[b*8 +: 8] = mem[8'(a + 32'(b))];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- memory model (driven at negedge) ----------------
    int          timer = 0;
    int          lat_sel = 0;
    bit          spur_pend = 0;
    logic [31:0] pend_addr;
    logic        pend_wide;

    always @(negedge clk) begin
        logic [63:0] v;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        if (timer > 0) begin
            timer--;
            if (timer == 0) begin
                v = pend_wide ? rd(pend_addr, 8) : {32'hA5A5_5A5A, rd(pend_addr, 4)[31:0]};
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = v;
            end
        end
        if (spur_pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = 64'hDEAD_BEEF_0BAD_F00D;
            spur_pend     = 0;
        end
        if (rst_n && mem_req_valid) begin
            pend_addr = mem_req_addr;
            pend_wide = mem_req_wide;
            timer     = 1 + (lat_sel % 3);
            lat_sel++;
        end
    end

    // ---------------- reference model (updated at posedge) ----------------
    int           ph = 0;            // 0 idle, 1 request, 2 waiting, 3 complete
    int           lane_q[$];
    logic [31:0]  addr_q[$];
    logic [127:0] mres = '0;
    logic         mwide = 1'b0;
    int           exp_pop = 0;

    always @(posedge clk) begin
        int old;
        if (!rst_n) begin
            ph = 0; lane_q.delete(); addr_q.delete(); mres = '0; mwide = 0; exp_pop = 0;
        end else begin
            old = ph;
            case (ph)
                1: ph = 2;
                2: if (mem_rsp_valid) begin
                       if (mwide) mres[lane_q[0]*64 +: 64] = rd(addr_q[0], 8);
                       else       mres[lane_q[0]*32 +: 32] = rd(addr_q[0], 4)[31:0];
                       void'(lane_q.pop_front());
                       void'(addr_q.pop_front());
                       ph = (lane_q.size() == 0) ? 3 : 1;
                   end
                default: ph = 0;
            endcase
            if ((old == 0 || old == 3) && cmd_valid) begin
                int nl, es, k;
                nl = cmd_wide ? 2 : 4;
                es = cmd_wide ? 8 : 4;
                mwide = cmd_wide;
                mres = '0;
                lane_q.delete(); addr_q.delete();
                k = 0;
                for (int j = 0; j < 4; j++) begin
                    if (j < nl && cmd_mask[j]) begin
                        lane_q.push_back(j);
                        addr_q.push_back(cmd_addr + 32'(k * es));
                        k++;
                    end else if (j < nl && !cmd_zero) begin
                        if (cmd_wide) mres[j*64 +: 64] = cmd_src[j*64 +: 64];
                        else          mres[j*32 +: 32] = cmd_src[j*32 +: 32];
                    end
                end
                exp_pop = k;
                ph = (k == 0) ? 3 : 1;
            end
        end
    end

    // ---------------- per-clock comparison ----------------
    int reqs = 0;
    always @(negedge clk) begin
        if (running) begin
            chk("R1 cmd_ready", 128'(cmd_ready), 128'(ph == 0 || ph == 3));
            chk("R6 R8 request strobe", 128'(mem_req_valid), 128'(ph == 1));
            if (ph == 1 && mem_req_valid) begin
                chk("R4 request address", 128'(mem_req_addr), 128'(addr_q[0]));
                chk("R2 request width", 128'(mem_req_wide), 128'(mwide));
            end
            chk("R7 done pulse", 128'(res_done), 128'(ph == 3));
            if (ph == 0 || ph == 3)
                chk("R3 R5 result vector", res_data, mres);
            if (mem_req_valid) reqs++;
            if (res_done) begin
                chk("R6 request count", 128'(reqs), 128'(exp_pop));
                reqs = 0;
            end
        end
    end

    // ---------------- stimulus ----------------
    int b2b = 0;

    task automatic issue(input logic [31:0] a, input logic [3:0] m, input logic w,
                         input logic z, input logic [127:0] s);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        if (res_done) b2b++;
        cmd_addr = a; cmd_mask = m; cmd_wide = w; cmd_zero = z; cmd_src = s;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(cmd_ready && !res_done)) @(negedge clk);
    endtask

    localparam logic [127:0] SRC_A = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    localparam logic [127:0] SRC_B = 128'hCAFE_0001_CAFE_0002_CAFE_0003_CAFE_0004;

    initial begin
        logic [127:0] saved;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_mask = '0;
        cmd_wide = 1'b0; cmd_zero = 1'b0; cmd_src = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset ready", 128'(cmd_ready), 128'(1));
        chk("R9 reset request", 128'(mem_req_valid), 128'(0));
        chk("R9 reset done", 128'(res_done), 128'(0));
        chk("R9 reset result", res_data, 128'(0));
        running = 1;

        issue(32'd3,  4'b1011, 1'b0, 1'b0, SRC_A);   // scattered, unaligned, merge
        issue(32'd17, 4'b0110, 1'b0, 1'b1, SRC_B);   // middle lanes, zero
        issue(32'd5,  4'b0010, 1'b1, 1'b0, SRC_A);   // 64-bit, upper lane only
        issue(32'd40, 4'b1101, 1'b1, 1'b1, SRC_B);   // 64-bit, R2 upper mask bits ignored
        issue(32'd9,  4'b1111, 1'b0, 1'b0, SRC_B);   // all narrow lanes
        issue(32'd61, 4'b0011, 1'b1, 1'b0, SRC_A);   // both wide lanes
        wait_idle();

        issue(32'd0, 4'b0000, 1'b0, 1'b0, SRC_A);
        chk("R12 empty mask done next cycle", 128'(res_done), 128'(1));
        chk("R12 empty mask no request", 128'(mem_req_valid), 128'(0));
        issue(32'd0, 4'b1100, 1'b1, 1'b1, SRC_B);     // wide, only ignored bits set
        chk("R12 R2 ignored bits give empty mask", 128'(res_done), 128'(1));
        wait_idle();

        saved = res_data;
        @(posedge clk);
        spur_pend = 1;
        @(negedge clk);
        @(negedge clk);
        chk("R11 stray reply leaves result", res_data, saved);
        chk("R11 stray reply leaves idle", 128'(cmd_ready), 128'(1));

        issue(32'd130, 4'b0101, 1'b0, 1'b1, SRC_A);
        issue(32'd77,  4'b1000, 1'b0, 1'b0, SRC_B);
        issue(32'd200, 4'b0001, 1'b1, 1'b0, SRC_B);
        wait_idle();
        chk("R10 back-to-back acceptance seen", 128'(b2b > 0), 128'(1));

        running = 0;
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule